// File: doc/BRIEF.md
# Flash Write-Cycle Qualification Guard

This block stands between the host bus strobes of a flash device and its command register. It decides when a host write counts as a real write cycle. The active-low chip-enable, write-enable and output-enable lines are sampled by a fast internal clock. Each line passes through a two-flop synchronizer and then a glitch filter. A line's filtered level changes only after the raw line has held its new level for `GLITCH_CYC` consecutive samples.

A write cycle opens when the filtered strobes reach the writing combination: chip-enable low, write-enable low and output-enable high. It closes on the filtered rising edge of write-enable, and at that point the block emits a one-cycle write-accepted pulse. Writes are suppressed in two cases. The first is while a digitized low-supply lockout flag is active; that flag also drives a request that returns the command state machine to read mode. The second is the first write-enable rise after power-up, if the device came out of reset with the writing combination already applied.

Top module: `flash_wr_guard`

## Requirements
- R1: `wr_accept` pulses only for a write in which the filtered chip-enable is 0 and output-enable is 1 while write-enable is 0. Any other chip-enable/output-enable combination produces no pulse when write-enable rises.
- R2: A qualified write produces exactly one `wr_accept` pulse, and that pulse lasts exactly one clock cycle.
- R3: A low pulse on `we_n` lasting fewer than `GLITCH_CYC` clock samples produces no pulse. A low pulse of `GLITCH_CYC` samples or more produces one pulse.
- R4: `read_reset_req` is 1 in the cycle after any edge at which `lockout` is 1. It is 0 in the cycle after an edge at which `lockout` is 0.
- R5: No `wr_accept` pulse is issued while `lockout` is 1, and writes made during lockout are discarded. After `lockout` returns to 0, a fresh write is accepted.
- R6: If `lockout` is 1 at any edge between the start of a write and its accepting edge, that write is dropped. This holds even when `lockout` has cleared again before write-enable rises.
- R7: While `rst_n` is 0, `wr_accept` is 0 and `read_reset_req` is 1.
- R8: If `ce_n`=0, `we_n`=0 and `oe_n`=1 are applied through power-on reset, the first rise of `we_n` afterwards is not accepted. The next complete write is accepted.
- R9: For a raw `we_n` rise driven before clock edge 1, `wr_accept` is visible after edge `GLITCH_CYC`+3. That delay is two synchronizer stages, `GLITCH_CYC` filter samples and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| ce_n | input | 1 | Raw chip-enable strobe, active low |
| we_n | input | 1 | Raw write-enable strobe, active low |
| oe_n | input | 1 | Raw output-enable strobe, active low |
| lockout | input | 1 | Digitized low-supply flag, active high, synchronous to clk |
| wr_accept | output | 1 | One-cycle pulse for each accepted write cycle |
| read_reset_req | output | 1 | Request to return the command state machine to read mode |

## Verification
The lockout flag and the write-accept decision can land on the same clock edge, which is the filtered rising edge of write-enable. The bench provokes this by arming a valid write and then sliding a one-cycle lockout pulse across each edge from the raw write-enable rise onward. It repeats this for every offset. The expected result is computed from the offset alone: the write is accepted only when the pulse lands after edge `GLITCH_CYC`+3. A second sweep covers strobe polarity against write-enable pulse length, where the expected acceptance and its exact latency follow from R1, R3 and R9.

// File: rtl/wg_pkg.sv
// Shared definitions for the flash write-cycle guard.
// Assumes the three strobes are always carried as one vector in this bit order.
package wg_pkg;
    localparam int NSTB   = 3;
    localparam int STB_CE = 0;
    localparam int STB_WE = 1;
    localparam int STB_OE = 2;
    typedef logic [NSTB-1:0] stb_vec_t;
endpackage

// File: rtl/wg_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous lines.
// Assumes each bit is unrelated to the others (no bus coherency needed).
module wg_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1;

    // Two register stages settle metastability before qualification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/wg_filter.sv
// Glitch filter for one synchronized strobe line.
// The output takes a new level only after the input has differed from it
// for GLITCH_CYC consecutive samples. Assumes GLITCH_CYC >= 1.
module wg_filter #(
    parameter int GLITCH_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

    logic [CW-1:0] run;

    // Count consecutive disagreeing samples and commit the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            run <= '0;
        end else if (d == q) begin
            run <= '0;
        end else if (run == LAST) begin
            q   <= d;
            run <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    // A committed level must match the input seen at the committing edge.
    assert_filter_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q != $past(q)) |-> ($past(d) == q));
endmodule

// File: rtl/wg_qual.sv
// Write-cycle qualifier acting on filtered strobes.
// Arms on entry into the writing combination, accepts on the filtered rise of
// write-enable, and applies supply lockout and the power-up ignore rule.
// Assumes lockout is already synchronous to clk.
module wg_qual
    import wg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  stb_vec_t stb_f,
    input  logic     lockout,
    output logic     wr_accept,
    output logic     read_reset_req
);
    logic ce_f, we_f, oe_f;
    logic we_q, combo_q, armed, pu_block;
    logic combo, start, we_rise;

    assign ce_f = stb_f[STB_CE];
    assign we_f = stb_f[STB_WE];
    assign oe_f = stb_f[STB_OE];

    // Decode the writing combination, its entry, and the write-enable rise.
    always_comb begin
        combo   = ~ce_f & ~we_f & oe_f;
        start   = combo & ~combo_q;
        we_rise = we_f & ~we_q;
    end

    // Track the write cycle state, the power-up block and both outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q           <= 1'b0;
            combo_q        <= 1'b0;
            armed          <= 1'b0;
            pu_block       <= 1'b1;
            wr_accept      <= 1'b0;
            read_reset_req <= 1'b1;
        end else begin
            we_q           <= we_f;
            combo_q        <= combo;
            if (we_f | ce_f)
                pu_block   <= 1'b0;
            armed          <= combo & ~lockout & ~pu_block & (armed | start);
            wr_accept      <= armed & we_rise & ~lockout;
            read_reset_req <= lockout;
        end
    end

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> !wr_accept);
    assert_lockout_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> !wr_accept);
    assert_no_arm_in_powerup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !pu_block);
    assert_accept_polarity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> (!$past(ce_f, 2) && $past(oe_f, 2)));
endmodule

// File: rtl/flash_wr_guard.sv
// Top of the flash write-cycle guard: synchronizes and filters the three bus
// strobes, then qualifies write cycles against supply lockout and power-up.
// Assumes rst_n is a synchronous power-on reset and lockout is synchronous to clk.
module flash_wr_guard
    import wg_pkg::*;
#(
    parameter int GLITCH_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic lockout,
    output logic wr_accept,
    output logic read_reset_req
);
    stb_vec_t raw, synced, filt;

    // Gather the raw strobes into the shared vector order.
    always_comb begin
        raw         = '0;
        raw[STB_CE] = ce_n;
        raw[STB_WE] = we_n;
        raw[STB_OE] = oe_n;
    end

    wg_sync #(.WIDTH(NSTB)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (synced)
    );

    for (genvar i = 0; i < NSTB; i++) begin : g_filt
        wg_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (synced[i]),
            .q    (filt[i])
        );
    end

    wg_qual u_qual (
        .clk           (clk),
        .rst_n         (rst_n),
        .stb_f         (filt),
        .lockout       (lockout),
        .wr_accept     (wr_accept),
        .read_reset_req(read_reset_req)
    );

    assert_rdreq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> read_reset_req);
    assert_rdreq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lockout |=> !read_reset_req);
endmodule

// File: tb/flash_wr_guard_test.sv
module flash_wr_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int G = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0, we_n = 1'b0, oe_n = 1'b1, lockout = 1'b0;
    logic wr_accept, read_reset_req;

    int checks = 0, fails = 0;
    int edge_n = 0, acc_cnt = 0, last_acc = 0, wide_cnt = 0;
    logic prev_acc = 1'b0;
    bit done = 1'b0;

    flash_wr_guard #(.GLITCH_CYC(G)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lockout(lockout), .wr_accept(wr_accept), .read_reset_req(read_reset_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) edge_n++;

    // Observe the pulse output halfway through each cycle.
    always @(negedge clk) begin
        if (wr_accept) begin
            acc_cnt++;
            last_acc = edge_n;
            if (prev_acc) wide_cnt++;
        end
        prev_acc = wr_accept;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One write: set ce/oe, hold we low for low_len cycles, then raise it.
    task automatic do_write(input logic c, input logic o, input int low_len,
                            output int n, output int lat);
        int t0, c0;
        ce_n = c; oe_n = o; we_n = 1'b1;
        idle(8);
        we_n = 1'b0;
        idle(low_len);
        we_n = 1'b1;
        t0 = edge_n;
        c0 = acc_cnt;
        idle(14);
        n = acc_cnt - c0;
        lat = last_acc - t0;
        ce_n = 1'b1; oe_n = 1'b1;
        idle(8);
    endtask

    initial begin
        int n, lat;
        // R7 and R8: writing combination held through reset.
        idle(3);
        chk(wr_accept == 1'b0, "R7 accept in reset", wr_accept, 0);
        chk(read_reset_req == 1'b1, "R7 read request in reset", read_reset_req, 1);
        rst_n = 1'b1;
        idle(12);
        we_n = 1'b1;
        begin
            int c0;
            c0 = acc_cnt;
            idle(14);
            chk(acc_cnt == c0, "R8 first rise ignored", acc_cnt - c0, 0);
        end
        ce_n = 1'b1;
        idle(8);
        do_write(1'b0, 1'b1, 6, n, lat);
        chk(n == 1, "R8 next write accepted", n, 1);
        chk(read_reset_req == 1'b0, "R4 request clear", read_reset_req, 0);

        // R1, R3, R9: polarity by pulse-length sweep.
        for (int c = 0; c < 2; c++) begin
            for (int o = 0; o < 2; o++) begin
                for (int len = 1; len <= 6; len++) begin
                    int exp_n;
                    exp_n = (c == 0 && o == 1 && len >= G) ? 1 : 0;
                    do_write(c[0], o[0], len, n, lat);
                    chk(n == exp_n, (c == 0 && o == 1) ? "R3 glitch length" : "R1 inhibit", n, exp_n);
                    if (exp_n == 1)
                        chk(lat == G + 3, "R9 latency", lat, G + 3);
                end
            end
        end

        // R4 and R5: long lockout.
        lockout = 1'b1;
        idle(3);
        chk(read_reset_req == 1'b1, "R4 request during lockout", read_reset_req, 1);
        do_write(1'b0, 1'b1, 6, n, lat);
        chk(n == 0, "R5 write during lockout", n, 0);
        lockout = 1'b0;
        idle(3);
        chk(read_reset_req == 1'b0, "R4 request after lockout", read_reset_req, 0);
        do_write(1'b0, 1'b1, 6, n, lat);
        chk(n == 1, "R5 write after lockout", n, 1);

        // R6: one-cycle lockout pulse slid across the accepting window.
        for (int k = 1; k <= 10; k++) begin
            int c0, exp_n;
            ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
            idle(8);
            we_n = 1'b0;
            idle(8);
            c0 = acc_cnt;
            for (int e = 1; e <= 14; e++) begin
                lockout = (e == k);
                if (e == 1) we_n = 1'b1;
                @(posedge clk);
                @(negedge clk);
            end
            lockout = 1'b0;
            exp_n = (k >= G + 4) ? 1 : 0;
            chk(acc_cnt - c0 == exp_n, "R6 lockout collision", acc_cnt - c0, exp_n);
            ce_n = 1'b1;
            idle(8);
        end

        // R2: no pulse ever lasted beyond one cycle.
        chk(wide_cnt == 0, "R2 pulse width", wide_cnt, 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end
endmodule